// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture

This block timestamps external events against a 16-bit free-running counter. Each of two capture inputs passes through a synchroniser and an edge detector whose polarity software selects. When the chosen edge arrives, the channel copies the counter into its own read-only capture register and raises its capture flag.

The counter advances once per prescaler period. The period is a fixed division of the core clock, or one count per rising edge of a synchronised external clock input. A single interrupt enable covers both flags. A global mask input holds the request back while it is high, and the request stays pending until the mask drops.

Software uses a small byte-wide register bus. It writes a control byte, reads a status byte and reads each capture register as a high and a low byte. A flag is cleared by reading status while that flag is set and then accessing the channel's low capture byte.

Top module: `dual_capture_timer`

## Requirements
- R1: After synchronous reset the control byte, status byte, both capture registers and the counter are zero, and `irq` is low.
- R2: On an active edge of `cap_pin[i]`, channel i loads the counter value from the cycle in which the edge leaves a two-stage synchroniser. That is the counter value held between the second and third rising clock edges after the pin changes. The same event sets status bit i.
- R3: Control bit i (bit 0 for channel 0, bit 1 for channel 1) selects the active edge of channel i: 1 is rising and 0 is falling. The opposite edge leaves the flag and the capture register unchanged.
- R4: The bus uses these addresses: 0 is control and reads back all 8 bits as written, 1 is status, 2 and 3 are the high and low bytes of channel 0, and 4 and 5 are those of channel 1. Writes to the capture addresses do not change the stored values. `bus_rdata` is the selected byte while `bus_rd` is high.
- R5: `irq` is high exactly when control bit 2 is set, at least one flag is set and `irq_mask` is low. A request held back by the mask appears once the mask drops.
- R6: A flag clears on the clock edge of a read or write of its channel's low capture byte, provided a status read was seen earlier while that flag was set.
- R7: A low-byte access with no earlier arming status read leaves the flag set. A status read made while the flag is clear does not arm the channel.
- R8: A capture on a channel cancels its pending arming, whether the capture falls between the arming read and the low-byte access or in the same cycle as that access. The flag stays set and the capture register takes the new value.
- R9: Control bits 4:3 select the counter rate. Code 0 divides by 4, code 1 by 2 and code 2 by 8. The counter increments at the end of every core-clock cycle n (counted from 0 after reset) for which n mod divisor equals divisor minus 1.
- R10: With code 3 the counter increments once per rising edge of `ext_clk` after a two-stage synchroniser, and otherwise holds.
- R11: The channels are independent. Both can capture in the same cycle, and clearing one flag leaves the other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| cap_pin | input | 2 | Asynchronous capture inputs, bit i for channel i |
| ext_clk | input | 1 | Asynchronous external counter clock |
| irq_mask | input | 1 | Global interrupt mask, high blocks irq |
| irq | output | 1 | Capture interrupt request |

## Verification
A synchronised capture edge and the low-byte access that would clear the same flag can land on one clock edge. The bench provokes this by changing the pin two clock edges before it issues the low-byte read, so that the synchronised edge is seen in exactly the cycle of the access. It then requires the interrupt to stay high and the capture register to hold the counter value of that cycle. Captures on both channels in the same cycle are provoked as well, by changing both pins together; both registers must then hold the same counter value, and clearing one flag must leave the other set.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
   localparam int NCH = 2;

   typedef enum logic [1:0] {
      CLK_DIV4 = 2'd0,
      CLK_DIV2 = 2'd1,
      CLK_DIV8 = 2'd2,
      CLK_EXT  = 2'd3
   } clk_sel_e;

   localparam int A_CTRL = 0;
   localparam int A_STAT = 1;
   localparam int A_CAP0 = 2;   // channel i high byte at A_CAP0+2i, low at +1

   localparam int CTRL_IE  = 2;
   localparam int CTRL_SEL = 3;
endpackage

// File: rtl/dct_sync.sv
`timescale 1ns/1ps
module dct_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   input  logic pol,
   output logic hit
);
   localparam int LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("dct_sync: STAGES must be at least 2");
   end

   logic [LAST:0] pipe;

   for (genvar g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) pipe[g] <= 1'b0;
            else     pipe[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) pipe[g] <= 1'b0;
            else     pipe[g] <= pipe[g-1];
         end
      end
   end

   always_comb begin
      if (pol) hit = pipe[LAST-1] & ~pipe[LAST];
      else     hit = ~pipe[LAST-1] & pipe[LAST];
   end
endmodule

// File: rtl/dct_timebase.sv
`timescale 1ns/1ps
module dct_timebase
   import dct_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       clk_sel,
   input  logic             ext_clk,
   output logic [CNT_W-1:0] count
);
   localparam int MAX_DIV = 8;
   localparam int PRE_W   = $clog2(MAX_DIV);

   if (CNT_W < 2) begin : g_bad_width
      $error("dct_timebase: CNT_W too small");
   end

   logic [PRE_W-1:0] pre;
   logic             tick;
   logic             ext_hit;

   dct_sync #(.STAGES(SYNC_N)) u_ext_sync (
      .clk (clk),
      .rst (rst),
      .d   (ext_clk),
      .pol (1'b1),
      .hit (ext_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) pre <= '0;
      else     pre <= pre + 1'b1;
   end

   always_comb begin
      unique case (clk_sel_e'(clk_sel))
         CLK_DIV4: tick = &pre[1:0];
         CLK_DIV2: tick = pre[0];
         CLK_DIV8: tick = &pre;
         CLK_EXT:  tick = ext_hit;
         default:  tick = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)       count <= '0;
      else if (tick) count <= count + 1'b1;
   end

   a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
      (count != $past(count)) |-> (count == $past(count) + CNT_W'(1)));

   a_r10_ext_idle: assert property (@(posedge clk) disable iff (rst)
      (clk_sel == 2'(CLK_EXT) && !ext_hit) |=> $stable(count));
endmodule

// File: rtl/dct_channel.sv
`timescale 1ns/1ps
module dct_channel #(
   parameter int CNT_W  = 16,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pin,
   input  logic             rise_sel,
   input  logic [CNT_W-1:0] count,
   input  logic             stat_rd,
   input  logic             lo_acc,
   output logic             flag,
   output logic [CNT_W-1:0] cap
);
   logic evt;
   logic armed;

   dct_sync #(.STAGES(SYNC_N)) u_pin_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin),
      .pol (rise_sel),
      .hit (evt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cap <= '0;
      end else if (evt) begin
         cap <= count;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else if (evt) begin
         flag  <= 1'b1;
         armed <= 1'b0;
      end else if (armed && lo_acc) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else if (stat_rd && flag) begin
         armed <= 1'b1;
      end
   end

   a_r2_flag_on_capture: assert property (@(posedge clk) disable iff (rst)
      evt |=> flag);

   a_r3_cap_hold: assert property (@(posedge clk) disable iff (rst)
      !evt |=> $stable(cap));

   a_r6_clear_needs_arm: assert property (@(posedge clk) disable iff (rst)
      $fell(flag) |-> $past(armed && lo_acc));
endmodule

// File: rtl/dct_busif.sv
`timescale 1ns/1ps
module dct_busif
   import dct_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      rd_en,
   input  logic                      wr_en,
   input  logic [7:0]                wdata,
   input  logic [NCH-1:0]            flags,
   input  logic [NCH-1:0][CNT_W-1:0] caps,
   output logic [7:0]                ctrl,
   output logic [7:0]                rdata,
   output logic                      stat_rd,
   output logic [NCH-1:0]            lo_acc
);
   localparam int NREG = A_CAP0 + 2 * NCH;

   if (NREG > (1 << ADDR_W)) begin : g_bad_addr
      $error("dct_busif: ADDR_W too narrow for the register map");
   end
   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
      $error("dct_busif: CNT_W must lie in 9..16");
   end

   logic [NCH-1:0][7:0] hi_b;
   logic [NCH-1:0][7:0] lo_b;
   logic [NCH-1:0]      hi_sel;
   logic [NCH-1:0]      lo_sel;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam int HI_A = A_CAP0 + 2 * g;
      localparam int LO_A = HI_A + 1;
      logic [15:0] wide;
      assign wide      = 16'(caps[g]);
      assign hi_b[g]   = wide[15:8];
      assign lo_b[g]   = wide[7:0];
      assign hi_sel[g] = (addr == ADDR_W'(HI_A));
      assign lo_sel[g] = (addr == ADDR_W'(LO_A));
      assign lo_acc[g] = lo_sel[g] && (rd_en || wr_en);
   end

   assign stat_rd = rd_en && (addr == ADDR_W'(A_STAT));

   always_ff @(posedge clk) begin
      if (rst)                                     ctrl <= '0;
      else if (wr_en && addr == ADDR_W'(A_CTRL))   ctrl <= wdata;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr == ADDR_W'(A_CTRL)) rdata = ctrl;
         if (addr == ADDR_W'(A_STAT)) rdata = 8'(flags);
         for (int i = 0; i < NCH; i++) begin
            if (hi_sel[i]) rdata = hi_b[i];
            if (lo_sel[i]) rdata = lo_b[i];
         end
      end
   end

   a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && addr == ADDR_W'(A_CTRL)) |=> $stable(ctrl));
endmodule

// File: rtl/dual_capture_timer.sv
`timescale 1ns/1ps
module dual_capture_timer
   import dct_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [NCH-1:0]    cap_pin,
   input  logic              ext_clk,
   input  logic              irq_mask,
   output logic              irq
);
   logic [7:0]                ctrl;
   logic [CNT_W-1:0]          count;
   logic [NCH-1:0]            flags;
   logic [NCH-1:0][CNT_W-1:0] caps;
   logic                      stat_rd;
   logic [NCH-1:0]            lo_acc;

   dct_busif #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bus (
      .clk     (clk),
      .rst     (rst),
      .addr    (bus_addr),
      .rd_en   (bus_rd),
      .wr_en   (bus_wr),
      .wdata   (bus_wdata),
      .flags   (flags),
      .caps    (caps),
      .ctrl    (ctrl),
      .rdata   (bus_rdata),
      .stat_rd (stat_rd),
      .lo_acc  (lo_acc)
   );

   dct_timebase #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_time (
      .clk     (clk),
      .rst     (rst),
      .clk_sel (ctrl[CTRL_SEL+1:CTRL_SEL]),
      .ext_clk (ext_clk),
      .count   (count)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      dct_channel #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_chan (
         .clk      (clk),
         .rst      (rst),
         .pin      (cap_pin[g]),
         .rise_sel (ctrl[g]),
         .count    (count),
         .stat_rd  (stat_rd),
         .lo_acc   (lo_acc[g]),
         .flag     (flags[g]),
         .cap      (caps[g])
      );
   end

   assign irq = ctrl[CTRL_IE] & (|flags) & ~irq_mask;
endmodule

// File: tb/dual_capture_timer_test.sv
`timescale 1ns/1ps
module dual_capture_timer_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] addr = '0;
   logic       rd = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [1:0] pins = '0;
   logic       ext_clk = 1'b0;
   logic       irq_mask = 1'b0;
   logic       irq;

   int   checks = 0;
   int   fails = 0;
   bit   done = 1'b0;

   logic [1:0]  b_sel = 2'd0;
   int          m_n;
   logic [15:0] m_cnt;

   always #2.5 clk = ~clk;

   dual_capture_timer uut (
      .clk       (clk),
      .rst       (rst),
      .bus_addr  (addr),
      .bus_rd    (rd),
      .bus_wr    (wr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .cap_pin   (pins),
      .ext_clk   (ext_clk),
      .irq_mask  (irq_mask),
      .irq       (irq)
   );

   function automatic int div_of(input logic [1:0] s);
      case (s)
         2'd0:    return 4;
         2'd1:    return 2;
         2'd2:    return 8;
         default: return 1;
      endcase
   endfunction

   // counter model from the R9 arithmetic
   always @(posedge clk) begin
      if (rst) begin
         m_n   <= 0;
         m_cnt <= '0;
      end else begin
         if (b_sel != 2'd3 && (m_n % div_of(b_sel)) == div_of(b_sel) - 1)
            m_cnt <= m_cnt + 16'd1;
         m_n <= m_n + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(posedge clk);
      #1 rd = 1'b0;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk);
      #1 wr = 1'b0;
   endtask

   task automatic set_ctrl(input logic [1:0] sel, input logic ie, input logic [1:0] rise);
      wr_reg(3'd0, {3'b000, sel, ie, rise});
      b_sel = sel;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      #1;
   endtask

   // drive a pin level; expected capture is the model count between 2nd and 3rd edges
   task automatic pin_edge(input int ch, input logic lvl, output logic [15:0] exp);
      @(negedge clk);
      pins[ch] = lvl;
      @(posedge clk);
      @(posedge clk);
      #1 exp = m_cnt;
      @(posedge clk);
      #1;
   endtask

   task automatic cap_rise(input int ch, output logic [15:0] exp);
      @(negedge clk);
      pins[ch] = 1'b0;
      settle();
      pin_edge(ch, 1'b1, exp);
   endtask

   // full clearing read: status, high byte, low byte
   task automatic take(input int ch, output logic [15:0] v);
      logic [7:0] s, h, l;
      rd_reg(3'd1, s);
      rd_reg(3'(2 + 2 * ch), h);
      rd_reg(3'(3 + 2 * ch), l);
      v = {h, l};
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog got=running exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0]  d, h, l;
      logic [15:0] e, e2, prev, v, a0, b0;

      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R1 reset state
      rd_reg(3'd0, d); chk("R1 ctrl", d, 8'h00);
      rd_reg(3'd1, d); chk("R1 status", d, 8'h00);
      rd_reg(3'd2, d); chk("R1 cap0 hi", d, 8'h00);
      rd_reg(3'd5, d); chk("R1 cap1 lo", d, 8'h00);
      chk("R1 irq", irq, 1'b0);

      // R2 R3 R6 R9 sweep: divider x channel x polarity
      for (int sel = 0; sel < 3; sel++) begin
         for (int ch = 0; ch < 2; ch++) begin
            for (int pol = 0; pol < 2; pol++) begin
               set_ctrl(2'(sel), 1'b0, {1'(pol), 1'(pol)});
               rd_reg(3'(2 + 2 * ch), h);
               rd_reg(3'(3 + 2 * ch), l);
               prev = {h, l};
               @(negedge clk);
               pins[ch] = ~1'(pol);
               settle();
               rd_reg(3'd1, d);
               chk("R3 inactive edge flag", d[ch], 1'b0);
               rd_reg(3'(2 + 2 * ch), h);
               rd_reg(3'(3 + 2 * ch), l);
               chk("R3 inactive edge cap", {h, l}, prev);
               pin_edge(ch, 1'(pol), e);
               rd_reg(3'd1, d);
               chk("R2 flag set", d[ch], 1'b1);
               rd_reg(3'(2 + 2 * ch), h);
               chk("R2 R9 cap hi", h, e[15:8]);
               rd_reg(3'(3 + 2 * ch), l);
               chk("R2 R9 cap lo", l, e[7:0]);
               rd_reg(3'd1, d);
               chk("R6 flag cleared", d[ch], 1'b0);
            end
         end
      end

      // R5 interrupt gating
      set_ctrl(2'd0, 1'b1, 2'b11);
      irq_mask = 1'b1;
      cap_rise(0, e);
      chk("R5 masked", irq, 1'b0);
      irq_mask = 1'b0;
      #1 chk("R5 pending released", irq, 1'b1);
      set_ctrl(2'd0, 1'b0, 2'b11);
      chk("R5 enable off", irq, 1'b0);
      set_ctrl(2'd0, 1'b1, 2'b11);
      chk("R5 enable on", irq, 1'b1);

      // R7 low-byte access without arming
      rd_reg(3'd3, d);
      chk("R7 read lo unarmed", irq, 1'b1);
      wr_reg(3'd3, 8'h5A);
      chk("R7 write lo unarmed", irq, 1'b1);
      take(0, v);
      chk("R6 cleared after sequence", irq, 1'b0);
      rd_reg(3'd1, d);
      cap_rise(0, e);
      rd_reg(3'd3, d);
      chk("R7 status read with flag clear", irq, 1'b1);
      take(0, v);
      chk("R6 cleared", irq, 1'b0);

      // R8 capture between arming and low access
      cap_rise(0, e);
      rd_reg(3'd1, d);
      cap_rise(0, e2);
      rd_reg(3'd3, d);
      chk("R8 capture cancels arming", irq, 1'b1);
      take(0, v);
      chk("R8 new value", v, e2);
      chk("R8 cleared later", irq, 1'b0);

      // R8 capture in the same cycle as the low access
      cap_rise(0, e);
      rd_reg(3'd1, d);
      @(negedge clk) pins[0] = 1'b0;
      settle();
      @(negedge clk) pins[0] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1 e2 = m_cnt;
      rd_reg(3'd3, d);
      chk("R8 same-cycle flag kept", irq, 1'b1);
      take(0, v);
      chk("R8 same-cycle value", v, e2);
      chk("R8 same-cycle cleared later", irq, 1'b0);

      // R11 simultaneous capture and independent clearing
      @(negedge clk) pins = 2'b00;
      settle();
      @(negedge clk) pins = 2'b11;
      @(posedge clk);
      @(posedge clk);
      #1 e = m_cnt;
      @(posedge clk);
      #1;
      rd_reg(3'd1, d);
      chk("R11 both flags", d[1:0], 2'b11);
      rd_reg(3'd2, h);
      rd_reg(3'd3, l);
      chk("R11 ch0 value", {h, l}, e);
      rd_reg(3'd1, d);
      chk("R11 ch1 flag survives", d[1:0], 2'b10);
      rd_reg(3'd4, h);
      rd_reg(3'd5, l);
      chk("R11 ch1 value", {h, l}, e);
      rd_reg(3'd1, d);
      chk("R11 both cleared", d[1:0], 2'b00);

      // R4 read-only capture bytes and control readback
      wr_reg(3'd2, 8'hA5);
      wr_reg(3'd5, 8'h3C);
      rd_reg(3'd2, h);
      rd_reg(3'd3, l);
      chk("R4 cap0 write ignored", {h, l}, e);
      rd_reg(3'd4, h);
      rd_reg(3'd5, l);
      chk("R4 cap1 write ignored", {h, l}, e);
      wr_reg(3'd0, 8'hE4);
      rd_reg(3'd0, d);
      chk("R4 ctrl readback", d, 8'hE4);
      rd_reg(3'd1, d);
      chk("R4 status unaffected", d, 8'h00);

      // R10 external clock mode
      set_ctrl(2'd3, 1'b0, 2'b11);
      cap_rise(0, e);
      take(0, a0);
      repeat (10) @(posedge clk);
      cap_rise(0, e);
      take(0, b0);
      chk("R10 idle without ext edges", b0, a0);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk) ext_clk = 1'b1;
         repeat (3) @(posedge clk);
         @(negedge clk) ext_clk = 1'b0;
         repeat (3) @(posedge clk);
      end
      cap_rise(1, e);
      take(1, v);
      chk("R10 five ext edges", v, a0 + 16'd5);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule